// File: doc/BRIEF.md
# Downstream Port Power Manager

This block drives the power-switch enables of four downstream ports of a hub and watches the overcurrent flags that the external switches return. Each overcurrent flag is active-low. A flag must hold steady low for a run of cycles before the block acts on it, so short spikes are rejected. When a flag is accepted, the block removes power and sets a sticky status bit that the hub logic reads and later clears. Power comes back only when the hub logic asks for it again.

Two configuration straps are captured while reset is held and are frozen afterwards. The first strap chooses the protection policy. In ganged policy, the four ports act as one group: any request, fault or clear applies to all of them, and their enables always switch together. In per-port policy, each port is independent. The second strap only records whether the hub draws its power from the bus, and the block reports it.

Top module: `dsport_pwr_mgr`

## Requirements
- R1: After synchronous reset, every power enable output is 1 (port unpowered, active-low) and every status bit is 0.
- R2: An overcurrent input (0 = overcurrent) is accepted once it has been sampled low on FILT_CYCLES consecutive rising edges (default 8). Power drops and status sets on the edge after that. A low run shorter than FILT_CYCLES changes nothing.
- R3: A status bit stays 1 until a clear pulse is applied to its port. If a fault and a clear arrive in the same cycle, the status bit stays set.
- R4: With the ganged strap at 0, an accepted overcurrent on a port powers down only that port and sets only that port's status bit.
- R5: With the ganged strap at 1, an accepted overcurrent on any input powers down all ports and sets all status bits.
- R6: With the ganged strap at 1, a power-on or power-off request on any port switches all four enables in the same cycle. The four enables never differ.
- R7: With the ganged strap at 1, a clear on any port clears all status bits.
- R8: A power-on request is ignored while the port's status bit is set, including in the cycle the clear is applied. Power returns only on a later power-on request, one cycle after it is sampled.
- R9: The two straps are loaded on every edge while reset is low and held after reset is released. Later changes on the strap inputs have no effect on behaviour or on the reported strap values.
- R10: Power-on and power-off requests act one cycle after they are sampled. If both arrive on a port in the same cycle, power-off wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_gang_i | input | 1 | Ganged-policy strap, captured during reset |
| strap_buspwr_i | input | 1 | Bus-powered strap, captured during reset |
| ovc_n_i | input | NUM_PORTS | Overcurrent flags, active low, synchronous to clk |
| req_on_i | input | NUM_PORTS | Power-on request pulses from hub logic |
| req_off_i | input | NUM_PORTS | Power-off request pulses from hub logic |
| stat_clr_i | input | NUM_PORTS | Status clear pulses from hub logic |
| pwr_en_n_o | output | NUM_PORTS | Power enables, active low, always driven |
| ovc_stat_o | output | NUM_PORTS | Latched overcurrent status bits |
| gang_mode_o | output | 1 | Captured ganged strap |
| bus_pwr_o | output | 1 | Captured bus-powered strap |

## Verification
The in-line assertions check four things on every cycle. An accepted fault turns power off and sets status on the next edge. Power never rises while status is latched. Ganged enables never differ. The captured straps never move outside reset. They also check that an accepted fault comes from a low input. Other behaviour shows only in the bench scenarios, which compare against a behavioural model: the exact spike length that is rejected, the per-port isolation of a fault, the group-wide clear, that a mid-run strap change has no effect, and that power-off beats power-on.

// File: rtl/dsport_pwr_pkg.sv
// Package: shared types for the downstream port power manager.
// Assumes: straps are plain single-bit levels.
package dsport_pwr_pkg;
    typedef struct packed {
        logic ganged;
        logic bus_powered;
    } strap_cfg_t;
endpackage

// File: rtl/ovc_filter.sv
// Module: ovc_filter
// Counts consecutive low samples of one overcurrent flag and reports an
// accepted fault once the run reaches FILT_CYCLES.
// Assumes: the flag is already synchronous to clk.
module ovc_filter #(
    parameter int FILT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovc_n,
    output logic fault
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] CMAX = CW'(FILT_CYCLES);

    logic [CW-1:0] run_q;

    // Purpose: length of the current low run, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= '0;
        else if (ovc_n)      run_q <= '0;
        else if (run_q != CMAX) run_q <= run_q + 1'b1;
    end

    assign fault = (run_q == CMAX);

    // An accepted fault must be backed by a low sample on the previous edge.
    p_fault_needs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(!ovc_n));
endmodule

// File: rtl/port_pwr_ctrl.sv
// Module: port_pwr_ctrl
// Power state and sticky overcurrent status of one port.
// Assumes: inputs already merged for the group policy by the parent.
module port_pwr_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic clr,
    input  logic req_on,
    input  logic req_off,
    output logic on_o,
    output logic stat_o
);
    logic on_q, stat_q;

    // Purpose: sticky status; a fault dominates a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     stat_q <= 1'b0;
        else if (fault) stat_q <= 1'b1;
        else if (clr)   stat_q <= 1'b0;
    end

    // Purpose: power state; fault and off beat on; on blocked while latched.
    always_ff @(posedge clk) begin
        if (!rst_n)                  on_q <= 1'b0;
        else if (fault || req_off)   on_q <= 1'b0;
        else if (req_on && !stat_q)  on_q <= 1'b1;
    end

    assign on_o   = on_q;
    assign stat_o = stat_q;

    p_fault_powers_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!on_q && stat_q));
    p_no_restore_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q |=> !$rose(on_q));
    p_clear_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !clr) |=> stat_q);
endmodule

// File: rtl/dsport_pwr_mgr.sv
// Module: dsport_pwr_mgr (top)
// Power enables and overcurrent status for NUM_PORTS downstream ports,
// under a ganged or per-port policy chosen by a strap captured in reset.
// Assumes: request, clear and overcurrent inputs are synchronous to clk.
module dsport_pwr_mgr
    import dsport_pwr_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int FILT_CYCLES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strap_gang_i,
    input  logic                 strap_buspwr_i,
    input  logic [NUM_PORTS-1:0] ovc_n_i,
    input  logic [NUM_PORTS-1:0] req_on_i,
    input  logic [NUM_PORTS-1:0] req_off_i,
    input  logic [NUM_PORTS-1:0] stat_clr_i,
    output logic [NUM_PORTS-1:0] pwr_en_n_o,
    output logic [NUM_PORTS-1:0] ovc_stat_o,
    output logic                 gang_mode_o,
    output logic                 bus_pwr_o
);
    strap_cfg_t cfg_q;
    logic [NUM_PORTS-1:0] fault_raw, on_vec;

    // Purpose: load straps while reset is held, freeze them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '{ganged: strap_gang_i, bus_powered: strap_buspwr_i};
    end

    logic any_fault, any_clr, any_on, any_off;
    assign any_fault = |fault_raw;
    assign any_clr   = |stat_clr_i;
    assign any_on    = |req_on_i;
    assign any_off   = |req_off_i;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic f_sel, c_sel, on_sel, off_sel;
        ovc_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk(clk), .rst_n(rst_n), .ovc_n(ovc_n_i[g]), .fault(fault_raw[g]));
        // Purpose: choose group-wide or own-port events per the policy.
        always_comb begin
            f_sel   = cfg_q.ganged ? any_fault : fault_raw[g];
            c_sel   = cfg_q.ganged ? any_clr   : stat_clr_i[g];
            on_sel  = cfg_q.ganged ? any_on    : req_on_i[g];
            off_sel = cfg_q.ganged ? any_off   : req_off_i[g];
        end
        port_pwr_ctrl u_ctrl (
            .clk(clk), .rst_n(rst_n), .fault(f_sel), .clr(c_sel),
            .req_on(on_sel), .req_off(off_sel),
            .on_o(on_vec[g]), .stat_o(ovc_stat_o[g]));
    end

    assign pwr_en_n_o  = ~on_vec;
    assign gang_mode_o = cfg_q.ganged;
    assign bus_pwr_o   = cfg_q.bus_powered;

    p_gang_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.ganged |-> ($countones(pwr_en_n_o) == 0 || $countones(pwr_en_n_o) == NUM_PORTS));
    p_strap_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q));
    p_gang_fault_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.ganged && any_fault) |=> (&pwr_en_n_o && &ovc_stat_o));
endmodule

// File: tb/dsport_pwr_mgr_bench.sv
// Bench: behavioural reference model compared on every falling edge,
// plus directed scenarios tagged by requirement.
module dsport_pwr_mgr_bench;
    localparam int N = 4;
    localparam int F = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap_gang = 1'b0, strap_bus = 1'b1;
    logic [N-1:0] ovc_n = '1, ron = '0, roff = '0, clr = '0;
    logic [N-1:0] en_n, stat;
    logic gmode, bmode;

    dsport_pwr_mgr #(.NUM_PORTS(N), .FILT_CYCLES(F)) u_dsport_pwr_mgr (
        .clk(clk), .rst_n(rst_n), .strap_gang_i(strap_gang), .strap_buspwr_i(strap_bus),
        .ovc_n_i(ovc_n), .req_on_i(ron), .req_off_i(roff), .stat_clr_i(clr),
        .pwr_en_n_o(en_n), .ovc_stat_o(stat), .gang_mode_o(gmode), .bus_pwr_o(bmode));

    always #4 clk = ~clk;

    int checks = 0, fails = 0, cycles = 0;
    string tag = "R1";

    // Reference model state.
    int  m_run [N];
    bit  m_on  [N];
    bit  m_st  [N];
    bit  m_gang, m_bus, m_valid = 0;

    always @(posedge clk) begin
        bit det [N];
        bit af, ac, ao, ax, f, c, o, x;
        cycles++;
        if (!rst_n) begin
            m_gang = strap_gang; m_bus = strap_bus;
            for (int i = 0; i < N; i++) begin m_run[i] = 0; m_on[i] = 0; m_st[i] = 0; end
        end else begin
            af = 0; ac = 0; ao = 0; ax = 0;
            for (int i = 0; i < N; i++) begin
                det[i] = (m_run[i] >= F);
                af |= det[i]; ac |= clr[i]; ao |= ron[i]; ax |= roff[i];
            end
            for (int i = 0; i < N; i++) begin
                f = m_gang ? af : det[i];
                c = m_gang ? ac : clr[i];
                o = m_gang ? ao : ron[i];
                x = m_gang ? ax : roff[i];
                if (f || x) m_on[i] = 0;
                else if (o && !m_st[i]) m_on[i] = 1;
                if (f) m_st[i] = 1;
                else if (c) m_st[i] = 0;
            end
            for (int i = 0; i < N; i++)
                m_run[i] = ovc_n[i] ? 0 : (m_run[i] < F ? m_run[i] + 1 : F);
        end
        m_valid = 1;
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        logic [N-1:0] exp_en, exp_st;
        if (m_valid) begin
            for (int i = 0; i < N; i++) begin exp_en[i] = !m_on[i]; exp_st[i] = m_st[i]; end
            checks++;
            if (en_n !== exp_en || stat !== exp_st || gmode !== m_gang || bmode !== m_bus) begin
                fails++;
                $display("FAIL %s: en_n=%b stat=%b g=%b b=%b expected en_n=%b stat=%b g=%b b=%b",
                         tag, en_n, stat, gmode, bmode, exp_en, exp_st, m_gang, m_bus);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic [N-1:0] sig, input logic [N-1:0] v);
        sig = v; step(1); sig = '0;
    endtask

    task automatic expect_out(input string t, input logic [N-1:0] e_en, input logic [N-1:0] e_st);
        checks++;
        if (en_n !== e_en || stat !== e_st) begin
            fails++;
            $display("FAIL %s: en_n=%b stat=%b expected en_n=%b stat=%b", t, en_n, stat, e_en, e_st);
        end
    endtask

    task automatic do_reset(input logic g);
        rst_n = 1'b0; strap_gang = g; step(3); rst_n = 1'b1; step(1);
    endtask

    initial begin
        // R1 / R9: per-port policy, bus powered.
        tag = "R1"; do_reset(1'b0);
        expect_out("R1", 4'b1111, 4'b0000);
        tag = "R10"; pulse(ron, 4'b1111);
        expect_out("R10", 4'b0000, 4'b0000);
        // R2: a 7-cycle spike on port 1 is ignored.
        tag = "R2"; ovc_n = 4'b1101; step(F - 1); ovc_n = '1; step(3);
        expect_out("R2", 4'b0000, 4'b0000);
        // R4: full-length fault on port 2 affects only port 2.
        tag = "R4"; ovc_n = 4'b1011; step(F); step(1);
        expect_out("R4", 4'b0100, 4'b0100);
        ovc_n = '1; step(1);
        // R8: on request ignored while latched, and in the clear cycle.
        tag = "R8"; pulse(ron, 4'b0100); step(1);
        expect_out("R8", 4'b0100, 4'b0100);
        clr = 4'b0100; ron = 4'b0100; step(1); clr = '0; ron = '0; step(1);
        expect_out("R8", 4'b0100, 4'b0000);
        pulse(ron, 4'b0100);
        expect_out("R8", 4'b0000, 4'b0000);
        // R3: clear while the fault persists leaves status set.
        tag = "R3"; ovc_n = 4'b1110; step(F + 2); pulse(clr, 4'b0001); step(1);
        expect_out("R3", 4'b0001, 4'b0001);
        ovc_n = '1; step(2); pulse(clr, 4'b0001); step(1);
        expect_out("R3", 4'b0001, 4'b0000);
        // R10: off wins over on in the same cycle; off on one port only.
        tag = "R10"; ron = 4'b1001; roff = 4'b1000; step(1); ron = '0; roff = '0; step(1);
        expect_out("R10", 4'b1000, 4'b0000);
        // R9: strap change after reset has no effect.
        tag = "R9"; strap_gang = 1'b1; strap_bus = 1'b0; step(2);
        checks++;
        if (gmode !== 1'b0 || bmode !== 1'b1) begin
            fails++; $display("FAIL R9: g=%b b=%b expected g=0 b=1", gmode, bmode);
        end
        ovc_n = 4'b0111; step(F + 1); ovc_n = '1; step(1);
        expect_out("R9", 4'b1000, 4'b1000);
        // Ganged policy.
        tag = "R9"; strap_bus = 1'b1; do_reset(1'b1);
        checks++;
        if (gmode !== 1'b1) begin fails++; $display("FAIL R9: g=%b expected 1", gmode); end
        tag = "R6"; pulse(ron, 4'b0001);
        expect_out("R6", 4'b0000, 4'b0000);
        pulse(roff, 4'b0100);
        expect_out("R6", 4'b1111, 4'b0000);
        pulse(ron, 4'b0010);
        tag = "R5"; ovc_n = 4'b0111; step(F + 1); ovc_n = '1;
        expect_out("R5", 4'b1111, 4'b1111);
        tag = "R7"; step(1); pulse(clr, 4'b0010);
        expect_out("R7", 4'b1111, 4'b0000);
        tag = "R8"; pulse(ron, 4'b1000);
        expect_out("R8", 4'b0000, 4'b0000);
        tag = "R2"; ovc_n = 4'b1110; step(F - 1); ovc_n = '1; step(2);
        expect_out("R2", 4'b0000, 4'b0000);
        step(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        wait (cycles > 20000);
        fails++; checks++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule